// File: doc/BRIEF.md
# Oscillator Sample Strobe and Wavetable Cursor

This block serves one oscillator of a wavetable voice. It receives a clock-enable pulse `tick_i` that arrives at 512 times the note frequency. A power-of-two divider turns these pulses into a one-cycle sample strobe. Each strobe also moves an 8-bit table cursor downward. Because the cursor falls through the table, the waveform is stored in memory with its time order reversed.

At high pitches the divide ratio grows from 2 to 4, 8 or 16 ticks. The cursor step grows with it, to 1, 2, 4 or 8 entries. Table entries are skipped, the sample rate stays a power-of-two multiple of the note pitch, and the pitch does not change.

Both the ratio select and the reload value are sampled only at a wrap. A wrap is the strobe at which the cursor would otherwise fall below zero, so a new setting never breaks a period in the middle. A voice uses two instances of the block, one for each oscillator.

Top module: `osc_sample_cursor`

## Requirements
- R1: During and right after reset, `cursor_o` is 0, `sample_o` is 0, and the active divide ratio is 2.
- R2: `ratio_sel_i` codes 0, 1, 2 and 3 select one strobe for every 2, 4, 8 and 16 `tick_i` pulses. The divide counter restarts after each strobe.
- R3: `sample_o` is high for exactly one clock. That clock is the one that follows the `tick_i` pulse completing the divide ratio.
- R4: `cursor_o` changes in the same clock in which `sample_o` goes high. It then holds the table index to read, which is the previous value minus the active step.
- R5: A strobe that finds the cursor below the active step is a wrap, and the cursor loads the reload value. After reset the cursor is 0, so the first strobe loads the reload value.
- R6: The active step is half the active divide ratio: 1, 2, 4 or 8.
- R7: `ratio_sel_i` and `reload_i` are sampled only at a wrap. A change at any other time has no effect until the next wrap.
- R8: While `tick_i` is low, `cursor_o` holds its value and `sample_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Enable pulse at 512x the note frequency |
| ratio_sel_i | input | 2 | Divide ratio code; the ratio is 2 shifted left by the code |
| reload_i | input | 8 | Start index loaded at a wrap |
| sample_o | output | 1 | One-clock sample strobe |
| cursor_o | output | 8 | Current wavetable index |

## Verification
The bench builds the block with its defaults: an 8-bit cursor and a 2-bit ratio select. This gives every ratio from divide-by-2 up to divide-by-16 and every step from 1 to 8. A full 256-entry sweep at step 1 exercises the wrap from index 0 back to 255. A short reload of 15 at step 8 causes a wrap on every second strobe. In that run the wrap test takes the path where the cursor is nonzero but still below the step. Setting changes made in the middle of a period show that both the old ratio and the old step stay active until the next wrap.

// File: rtl/osc_cur_pkg.sv
package osc_cur_pkg;
  localparam int unsigned CUR_W_DEF = 8;
  localparam int unsigned SEL_W_DEF = 2;

  typedef enum logic [1:0] {
    DIV2  = 2'd0,
    DIV4  = 2'd1,
    DIV8  = 2'd2,
    DIV16 = 2'd3
  } ratio_code_e;
endpackage

// File: rtl/osc_rate_div.sv
module osc_rate_div #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned CNT_W = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             evt_o,
  output logic             sample_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   ratio;
  logic             last;

  assign ratio = (CNT_W+1)'(2) << sel_i;
  assign last  = ({1'b0, cnt_q} == ratio - 1'b1);
  assign evt_o = tick_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sample_o <= 1'b0;
    end else begin
      sample_o <= evt_o;
      if (tick_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q} < ratio);
  assert_strobe_after_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> $past(tick_i));
  assert_strobe_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);
  assert_no_strobe_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !sample_o);
endmodule

// File: rtl/osc_cursor.sv
module osc_cursor #(
  parameter int unsigned CUR_W = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CUR_W-1:0] reload_i,
  output logic [SEL_W-1:0] sel_act_o,
  output logic [CUR_W-1:0] cursor_o
);
  logic [CUR_W:0]   step;
  logic             wrap;
  logic [SEL_W-1:0] sel_q;
  logic [CUR_W-1:0] cur_q;

  // step is half the divide ratio
  assign step      = (CUR_W+1)'(1) << sel_q;
  assign wrap      = ({1'b0, cur_q} < step);
  assign sel_act_o = sel_q;
  assign cursor_o  = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      sel_q <= '0;
    end else if (evt_i) begin
      if (wrap) begin
        cur_q <= reload_i;
        sel_q <= sel_i;
      end else begin
        cur_q <= cur_q - step[CUR_W-1:0];
      end
    end
  end

  assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> $stable(cur_q));
  assert_ratio_at_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_q) |-> $past(evt_i && wrap));
  assert_wrap_loads_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && wrap) |=> cur_q == $past(reload_i));
  assert_step_half_ratio_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !wrap) |=> ($past(cur_q) - cur_q) == (CUR_W'(1) << $past(sel_q)));
endmodule

// File: rtl/osc_sample_cursor.sv
module osc_sample_cursor
  import osc_cur_pkg::*;
#(
  parameter int unsigned CUR_W = CUR_W_DEF,
  parameter int unsigned SEL_W = SEL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  input  logic [CUR_W-1:0] reload_i,
  output logic             sample_o,
  output logic [CUR_W-1:0] cursor_o
);
  logic             evt;
  logic [SEL_W-1:0] sel_act;

  osc_rate_div #(.SEL_W(SEL_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .sel_i    (sel_act),
    .evt_o    (evt),
    .sample_o (sample_o)
  );

  osc_cursor #(.CUR_W(CUR_W), .SEL_W(SEL_W)) u_cur (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .sel_i     (ratio_sel_i),
    .reload_i  (reload_i),
    .sel_act_o (sel_act),
    .cursor_o  (cursor_o)
  );

  assert_cursor_on_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cursor_o) |-> sample_o);
endmodule

// File: tb/osc_sample_cursor_test.sv
module osc_sample_cursor_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] reload = 8'd255;
  logic       sample;
  logic [7:0] cursor;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int mcnt = 0;
  int msel = 0;
  int mcur = 0;

  always #4 clk = ~clk;

  osc_sample_cursor uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .ratio_sel_i (sel),
    .reload_i    (reload),
    .sample_o    (sample),
    .cursor_o    (cursor)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // one tick pulse, model update, then one idle clock
  task automatic tick_once(string req);
    bit ev;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    ev = (mcnt == (2 << msel) - 1);
    if (ev) begin
      mcnt = 0;
      if (mcur < (1 << msel)) begin
        mcur = int'(reload);
        msel = int'(sel);
      end else begin
        mcur = mcur - (1 << msel);
      end
    end else begin
      mcnt++;
    end
    check("R2 strobe", int'(sample), int'(ev));
    check(req, int'(cursor), mcur);
    @(negedge clk);
    check("R3 single", int'(sample), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 cursor", int'(cursor), 0);
    check("R1 strobe", int'(sample), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cursor after release", int'(cursor), 0);
    mcnt = 0; msel = 0; mcur = 0;
  endtask

  task automatic t_first_wrap;
    sel = 2'd0; reload = 8'd255;
    tick_once("R1 first tick no strobe");
    tick_once("R5 first strobe loads reload");
    check("R5 reload seen", int'(cursor), 255);
  endtask

  task automatic t_sweep_div2;
    for (int i = 0; i < 2 * 258; i++) tick_once("R4 step one");
    check("R5 wrapped past zero", int'(cursor), 253);
  endtask

  task automatic t_late_change;
    sel = 2'd3; reload = 8'd15;
    for (int i = 0; i < 20; i++) tick_once("R7 old ratio kept");
    for (int i = 0; i < 2 * 260; i++) tick_once("R7 applied at wrap");
    for (int i = 0; i < 16 * 6; i++) tick_once("R6 step eight");
  endtask

  task automatic t_div8;
    sel = 2'd2; reload = 8'd40;
    for (int i = 0; i < 8 * 12; i++) tick_once("R6 step four");
    sel = 2'd1; reload = 8'd9;
    for (int i = 0; i < 8 * 14; i++) tick_once("R2 ratio four");
  endtask

  task automatic t_idle;
    int held;
    held = int'(cursor);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      check("R8 no strobe", int'(sample), 0);
      check("R8 cursor held", int'(cursor), held);
    end
  endtask

  initial begin
    t_reset();
    t_first_wrap();
    t_sweep_div2();
    t_late_change();
    t_div8();
    t_idle();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule